// File: doc/BRIEF.md
# I2C Bus Condition Detector

This block sits between the two raw I2C pins and a slave protocol engine. It samples SCL and SDA with a fast system clock and passes each line through a synchronizer. A counter-based glitch filter then suppresses any level change that does not persist. The engine receives the two cleaned line levels and a set of one-cycle event pulses: START, STOP, SCL rising edge and SCL falling edge. It also receives a flag that shows whether the bus is idle.

A change on a filtered line becomes visible only after the synchronized input has held its new level for `GLITCH_CYCLES` consecutive system clocks. A spike shorter than that therefore never becomes a bit, a START or a STOP. An SDA transition while SCL is high is reported as a START or a STOP and never as a clock edge. A START that arrives while the bus is busy is still reported, which covers the repeated-START case.

Top module: `i2c_cond_detect`

## Requirements
- R1: A raw level change that is first sampled at clock edge k, and then held, appears on the filtered output (`scl_o` or `sda_o`) at edge k+GLITCH_CYCLES+1. Two synchronizer edges come first, then GLITCH_CYCLES consecutive disagreeing cycles; the output keeps its old value at every earlier edge.
- R2: A raw pulse held for fewer than GLITCH_CYCLES sampling edges changes neither filtered level and raises no event pulse. A pulse held for exactly GLITCH_CYCLES edges does pass.
- R3: `start_o` is high for exactly one cycle when filtered SDA goes from 1 to 0 while filtered SCL is 1, both in the cycle before the change and in the cycle of the change.
- R4: `stop_o` is high for exactly one cycle when filtered SDA goes from 0 to 1 while filtered SCL is 1, both before and during the change.
- R5: `scl_rise_o` and `scl_fall_o` are each high for exactly one cycle on a 0-to-1 or 1-to-0 change of filtered SCL.
- R6: An SDA change while SCL is high is a control condition: it produces no SCL edge pulse, and at most one of the four event pulses is high in any cycle.
- R7: `bus_idle_o` is 1 out of reset. It goes to 0 in the cycle after a START pulse and returns to 1 in the cycle after a STOP pulse.
- R8: A START that occurs while the bus is busy (a repeated START) still raises `start_o`, and `bus_idle_o` stays 0.
- R9: While `rst_n` is 0 and after its release, both filtered levels are 1, `bus_idle_o` is 1 and no event pulse is high, even if reset is applied in the middle of a transfer.
- R10: An SDA change while filtered SCL is 0 produces neither START nor STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_raw_i | input | 1 | Raw SCL pin level |
| sda_raw_i | input | 1 | Raw SDA pin level |
| scl_o | output | 1 | Filtered SCL level |
| sda_o | output | 1 | Filtered SDA level |
| start_o | output | 1 | One-cycle START pulse |
| stop_o | output | 1 | One-cycle STOP pulse |
| scl_rise_o | output | 1 | One-cycle SCL rising-edge pulse |
| scl_fall_o | output | 1 | One-cycle SCL falling-edge pulse |
| bus_idle_o | output | 1 | High while no transfer is open |

## Verification
A table walks the lines through a complete transfer:
- START, data bits with SDA changing under SCL low, STOP.
- A second transfer that ends in a repeated START.

Each step counts the event pulses, so the table separates conditions from clock edges and data changes. Glitches of GLITCH_CYCLES-1 and fewer cycles are placed on SCL during a low phase, on SDA while SCL is high, and on SDA from idle. These show that a short spike cannot form a clock edge, a false STOP or a false START. Directed tests pin down the exact latency edge, show that a pulse of exactly GLITCH_CYCLES passes while one cycle less does not, and apply reset in the middle of a transfer.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

  // Width of a counter that must hold values 0 .. n-1.
  function automatic int unsigned hold_cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // SDA falls while SCL is high on both sides of the change.
  function automatic logic is_start(input logic scl_prev, input logic sda_prev,
                                    input logic scl_now,  input logic sda_now);
    return scl_prev & scl_now & sda_prev & ~sda_now;
  endfunction

  // SDA rises while SCL is high on both sides of the change.
  function automatic logic is_stop(input logic scl_prev, input logic sda_prev,
                                   input logic scl_now,  input logic sda_now);
    return scl_prev & scl_now & ~sda_prev & sda_now;
  endfunction

  function automatic logic is_rise(input logic prev, input logic now);
    return ~prev & now;
  endfunction

  function automatic logic is_fall(input logic prev, input logic now);
    return prev & ~now;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic sync_o
);
  // The idle level of an I2C line is high, so the chain resets to ones.
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[STAGES-2:0], raw_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter
  import i2c_cond_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic level_o
);
  localparam int unsigned CNT_W = hold_cnt_width(HOLD_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] run_q;
  logic             level_q;
  logic             differs;

  assign differs = (in_i != level_q);

  // Count consecutive cycles in which the input disagrees with the held
  // level. Any agreeing cycle restarts the count.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= '0;
      level_q <= 1'b1;
    end else if (!differs) begin
      run_q   <= '0;
    end else if (run_q == LAST) begin
      run_q   <= '0;
      level_q <= in_i;
    end else begin
      run_q   <= run_q + 1'b1;
    end
  end

  assign level_o = level_q;
endmodule

// File: rtl/i2c_event_decode.sv
module i2c_event_decode
  import i2c_cond_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o,
  output logic idle_o
);
  logic scl_prev_q, sda_prev_q, busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_i;
      sda_prev_q <= sda_i;
    end
  end

  assign start_o = is_start(scl_prev_q, sda_prev_q, scl_i, sda_i);
  assign stop_o  = is_stop (scl_prev_q, sda_prev_q, scl_i, sda_i);
  assign rise_o  = is_rise (scl_prev_q, scl_i);
  assign fall_o  = is_fall (scl_prev_q, scl_i);

  // A transfer opens at any START (including a repeated one) and closes at STOP.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       busy_q <= 1'b0;
    else if (start_o) busy_q <= 1'b1;
    else if (stop_o)  busy_q <= 1'b0;
  end

  assign idle_o = ~busy_q;
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect #(
  parameter int unsigned SYNC_STAGES   = 2,
  parameter int unsigned GLITCH_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw_i,
  input  logic sda_raw_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic bus_idle_o
);
  localparam int unsigned NUM_LINES = 2;
  localparam int unsigned SCL_IDX   = 0;
  localparam int unsigned SDA_IDX   = 1;

  logic [NUM_LINES-1:0] raw_lines;
  logic [NUM_LINES-1:0] sync_lines;
  logic [NUM_LINES-1:0] clean_lines;

  // Named internal wires, observed by the bound checker.
  logic scl_sync_w, sda_sync_w;

  assign raw_lines[SCL_IDX] = scl_raw_i;
  assign raw_lines[SDA_IDX] = sda_raw_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2c_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (raw_lines[g]),
      .sync_o (sync_lines[g])
    );
    i2c_glitch_filter #(.HOLD_CYCLES(GLITCH_CYCLES)) filt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_i    (sync_lines[g]),
      .level_o (clean_lines[g])
    );
  end

  assign scl_sync_w = sync_lines[SCL_IDX];
  assign sda_sync_w = sync_lines[SDA_IDX];
  assign scl_o      = clean_lines[SCL_IDX];
  assign sda_o      = clean_lines[SDA_IDX];

  i2c_event_decode dec_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (clean_lines[SCL_IDX]),
    .sda_i   (clean_lines[SDA_IDX]),
    .start_o (start_o),
    .stop_o  (stop_o),
    .rise_o  (scl_rise_o),
    .fall_o  (scl_fall_o),
    .idle_o  (bus_idle_o)
  );
endmodule

// File: rtl/i2c_cond_detect_chk.sv
module i2c_cond_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_sync,
  input logic sda_sync,
  input logic scl_o,
  input logic sda_o,
  input logic start_o,
  input logic stop_o,
  input logic scl_rise_o,
  input logic scl_fall_o,
  input logic bus_idle_o
);
  // R1: a filtered level cannot move while its synchronized input agrees with it.
  a_r1_scl_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_sync == scl_o) |=> $stable(scl_o));
  a_r1_sda_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_sync == sda_o) |=> $stable(sda_o));

  a_r3_start_levels: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (scl_o && !sda_o));
  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  a_r4_stop_levels: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (scl_o && sda_o));
  a_r4_stop_single: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> !stop_o);

  a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise_o |=> !scl_rise_o);
  a_r5_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall_o |=> !scl_fall_o);

  a_r6_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o}));

  // R7 and R8: the idle flag follows conditions, repeated START included.
  a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !bus_idle_o);
  a_r7_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> bus_idle_o);
endmodule

bind i2c_cond_detect i2c_cond_detect_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_sync   (scl_sync_w),
  .sda_sync   (sda_sync_w),
  .scl_o      (scl_o),
  .sda_o      (sda_o),
  .start_o    (start_o),
  .stop_o     (stop_o),
  .scl_rise_o (scl_rise_o),
  .scl_fall_o (scl_fall_o),
  .bus_idle_o (bus_idle_o)
);

// File: tb/i2c_cond_detect_tb_top.sv
`timescale 1ns/1ps
module i2c_cond_detect_tb_top;
  localparam int N        = 4;      // glitch width in clocks
  localparam int SETTLE   = 12;     // hold long enough to pass the filter
  localparam int NV       = 20;
  localparam time WATCHDOG = 200000 * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_r = 1'b1, sda_r = 1'b1;
  logic scl_o, sda_o, start_o, stop_o, scl_rise_o, scl_fall_o, bus_idle_o;

  int checks = 0, fails = 0;
  int n_start = 0, n_stop = 0, n_rise = 0, n_fall = 0;

  always #4 clk = ~clk;   // 125 MHz

  i2c_cond_detect #(.SYNC_STAGES(2), .GLITCH_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_raw_i(scl_r), .sda_raw_i(sda_r),
    .scl_o(scl_o), .sda_o(sda_o), .start_o(start_o), .stop_o(stop_o),
    .scl_rise_o(scl_rise_o), .scl_fall_o(scl_fall_o), .bus_idle_o(bus_idle_o));

  // Event monitor: pulses last one clock, so one mid-cycle sample each.
  always @(negedge clk) begin
    if (rst_n) begin
      n_start += int'(start_o);
      n_stop  += int'(stop_o);
      n_rise  += int'(scl_rise_o);
      n_fall  += int'(scl_fall_o);
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Called at posedge+2; returns at posedge+2 after 'hold' edges.
  task automatic drive(input logic s, input logic d, input int hold);
    scl_r = s;
    sda_r = d;
    repeat (hold) @(posedge clk);
    #2;
  endtask

  // Vector layout: [17] scl [16] sda [15:11] hold [10:7] requirement number
  // [6] start [5] stop [4] rise [3] fall [2] idle [1] scl_o [0] sda_o
  localparam logic [17:0] VEC [NV] = '{
    {1'b1,1'b0,5'd12,4'd3 ,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R3 start from idle
    {1'b0,1'b0,5'd12,4'd5 ,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0}, // R5 fall
    {1'b0,1'b1,5'd12,4'd10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1}, // R10 data change
    {1'b1,1'b1,5'd12,4'd5 ,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1}, // R5 rise
    {1'b0,1'b1,5'd12,4'd5 ,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1},
    {1'b0,1'b0,5'd12,4'd10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b0,5'd3 ,4'd2 ,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0}, // R2 SCL spike N-1
    {1'b0,1'b0,5'd12,4'd2 ,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0},
    {1'b1,1'b0,5'd12,4'd5 ,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0},
    {1'b1,1'b1,5'd2 ,4'd2 ,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R2 SDA spike, no false stop
    {1'b1,1'b0,5'd12,4'd2 ,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0},
    {1'b1,1'b1,5'd12,4'd4 ,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1}, // R4 stop
    {1'b1,1'b0,5'd12,4'd6 ,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R6 no SCL edge with start
    {1'b0,1'b0,5'd12,4'd5 ,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0},
    {1'b0,1'b1,5'd12,4'd10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1},
    {1'b1,1'b1,5'd12,4'd5 ,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1},
    {1'b1,1'b0,5'd12,4'd8 ,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, // R8 repeated start
    {1'b1,1'b1,5'd12,4'd7 ,1'b0,1'b1,1'b0,1'b0,1'b1,1'b1,1'b1}, // R7 idle again
    {1'b1,1'b0,5'd1 ,4'd2 ,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1}, // R2 spike from idle
    {1'b1,1'b1,5'd12,4'd7 ,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b1}
  };

  initial begin
    #(WATCHDOG);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R9: state during reset
    chk("R9 scl_o in reset", int'(scl_o), 1);
    chk("R9 idle in reset", int'(bus_idle_o), 1);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 4);
    chk("R9 sda_o after reset", int'(sda_o), 1);
    chk("R9 idle after reset", int'(bus_idle_o), 1);
    chk("R9 no events after reset", n_start + n_stop + n_rise + n_fall, 0);

    // R1: exact latency of a held SCL change
    drive(1'b0, 1'b1, N + 1);
    chk("R1 scl_o before edge k+N+1", int'(scl_o), 1);
    @(posedge clk); #2;
    chk("R1 scl_o at edge k+N+1", int'(scl_o), 0);
    chk("R5 fall pulse at latency edge", int'(scl_fall_o), 1);
    drive(1'b0, 1'b1, SETTLE);
    drive(1'b1, 1'b1, SETTLE);
    chk("R1 idle kept over SCL-only toggle", int'(bus_idle_o), 1);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      int s0, p0, r0, f0;
      string tag;
      v = VEC[i];
      s0 = n_start; p0 = n_stop; r0 = n_rise; f0 = n_fall;
      tag = $sformatf("R%0d vec%0d", v[10:7], i);
      drive(v[17], v[16], int'(v[15:11]));
      chk({tag, " start"}, n_start - s0, int'(v[6]));
      chk({tag, " stop"},  n_stop  - p0, int'(v[5]));
      chk({tag, " rise"},  n_rise  - r0, int'(v[4]));
      chk({tag, " fall"},  n_fall  - f0, int'(v[3]));
      chk({tag, " idle"},  int'(bus_idle_o), int'(v[2]));
      chk({tag, " scl_o"}, int'(scl_o), int'(v[1]));
      chk({tag, " sda_o"}, int'(sda_o), int'(v[0]));
    end

    // R2 boundary: SDA pulse of exactly N edges passes, N-1 does not (SCL low)
    drive(1'b0, 1'b1, SETTLE);
    drive(1'b0, 1'b0, N);
    sda_r = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    chk("R2 pulse of N passes", int'(sda_o), 0);
    drive(1'b0, 1'b1, SETTLE);
    chk("R2 recovered after N pulse", int'(sda_o), 1);
    drive(1'b0, 1'b0, N - 1);
    sda_r = 1'b1;
    @(posedge clk); @(posedge clk); #2;
    chk("R2 pulse of N-1 blocked", int'(sda_o), 1);
    drive(1'b0, 1'b1, SETTLE);
    chk("R2 still high after N-1 pulse", int'(sda_o), 1);
    drive(1'b1, 1'b1, SETTLE);

    // R9: reset in the middle of a transfer
    drive(1'b1, 1'b0, SETTLE);
    chk("R9 busy before mid reset", int'(bus_idle_o), 0);
    rst_n = 1'b0;
    scl_r = 1'b1;
    sda_r = 1'b1;
    @(posedge clk); #2;
    chk("R9 idle during mid reset", int'(bus_idle_o), 1);
    chk("R9 sda_o during mid reset", int'(sda_o), 1);
    chk("R9 no start during reset", int'(start_o), 0);
    rst_n = 1'b1;
    begin
      int e0;
      e0 = n_start + n_stop + n_rise + n_fall;
      drive(1'b1, 1'b1, SETTLE);
      chk("R9 no events after mid reset", n_start + n_stop + n_rise + n_fall - e0, 0);
      chk("R9 idle after mid reset", int'(bus_idle_o), 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule